// File: doc/BRIEF.md
# Frame-Aware Token Issue Guard

This block sits in front of a host controller's token scheduler. It follows the current bit-time position inside a 1 ms bus frame with a counter. The counter returns to zero on every start-of-frame pulse and advances on each 12 MHz bit-time strobe. Isochronous work is placed at the start of each frame, and bulk and interrupt work follows it. A late transaction therefore risks running past the end of the frame.

When the scheduler presents the next transfer descriptor, the guard turns the descriptor's expected packet length into an estimated bus time. The estimate is a fixed token and handshake overhead plus the data bits, with an allowance for bit stuffing. The guard then checks whether the transaction would end before a guard band placed just ahead of the frame boundary. If it would, the token is released. If it would not, the token is held back and the descriptor is reported with the same status as a timeout. The scheduler receives the verdict one clock after it presented the descriptor.

Top module: `frame_token_guard`

## Requirements
- R1: While reset is asserted and right after it, stat_valid and token_go are 0, stat_code is 2'b00 and frame_pos is 0.
- R2: frame_pos goes to 0 on the clock after sof is high, even if tick is high in the same cycle. Otherwise it rises by one on each clock where tick is high, and holds on each clock where tick is low.
- R3: frame_pos saturates at FRAME_TICKS-1 (11999 by default) until the next sof.
- R4: The estimated duration is OVERHEAD_TICKS + ceil(desc_len*8*7/6) bit times, which is 50 + ceil(desc_len*56/6) by default.
- R5: If frame_pos + estimate <= FRAME_TICKS - GUARD_TICKS (11958 by default) in the cycle desc_valid is high, then on the next clock stat_valid=1, stat_code=2'b01 (issued) and token_go=1.
- R6: If that sum exceeds the limit, then on the next clock stat_valid=1, stat_code=2'b10 (suppressed, timeout status) and token_go=0.
- R7: On a clock that follows a cycle without desc_valid, stat_valid=0, stat_code=2'b00 and token_go=0.
- R8: Each verdict is based on the frame_pos value in the cycle the descriptor was presented. Descriptors presented on back-to-back cycles each get their own verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse |
| tick | input | 1 | Bit-time strobe (12 MHz enable) |
| desc_valid | input | 1 | A descriptor is presented this cycle |
| desc_len | input | LEN_W (11) | Expected packet length in bytes |
| stat_valid | output | 1 | Verdict valid |
| stat_code | output | 2 | 00 none, 01 issued, 10 suppressed/timeout |
| token_go | output | 1 | Token released to the bus |
| frame_pos | output | POS_W (14) | Current bit-time position in the frame |

## Verification
The bench places descriptors exactly at the last position that still fits, and one tick after it. It does this for a length whose stuffing allowance divides evenly and for one that must round up. A design that rounds down or forgets the guard band lets through a transaction that overruns by a single bit time. Other cases cover sof and tick arriving in the same cycle, and a frame that runs past its nominal end so the counter must saturate. A counter that wraps at this point would report an early position and release a late token. Back-to-back descriptors across a tick check that each verdict is based on the position in its own cycle and not on a stale one.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
  typedef enum logic [1:0] {
    ST_NONE    = 2'b00,
    ST_ISSUED  = 2'b01,
    ST_TIMEOUT = 2'b10
  } tok_stat_e;
endpackage

// File: rtl/ftg_frame_pos.sv
module ftg_frame_pos #(
  parameter int FRAME_TICKS = 12000,
  parameter int POS_W       = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             tick,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(FRAME_TICKS - 1);

  logic [POS_W-1:0] pos_d;
  logic             pos_en;

  always_comb begin
    pos_en = sof | (tick & (pos != POS_MAX));
    pos_d  = sof ? '0 : pos + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else if (pos_en) pos <= pos_d;
  end
endmodule

// File: rtl/ftg_estimator.sv
module ftg_estimator #(
  parameter int LEN_W          = 11,
  parameter int OVERHEAD_TICKS = 50,
  parameter int EST_W          = 17
) (
  input  logic [LEN_W-1:0] len,
  output logic [EST_W-1:0] est
);
  // data bits scaled by 7/6 for worst-case stuffing: len*56/6, rounded up
  logic [EST_W-1:0] bits_x7;
  logic [EST_W-1:0] stuffed;

  always_comb begin
    bits_x7 = EST_W'(len) * EST_W'(56);
    stuffed = (bits_x7 + EST_W'(5)) / EST_W'(6);
    est     = stuffed + EST_W'(OVERHEAD_TICKS);
  end
endmodule

// File: rtl/ftg_decider.sv
module ftg_decider
  import ftg_pkg::*;
#(
  parameter int POS_W = 14,
  parameter int EST_W = 17,
  parameter int LIMIT = 11958
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  input  logic [POS_W-1:0] pos,
  input  logic [EST_W-1:0] est,
  output logic             stat_valid,
  output tok_stat_e        stat,
  output logic             token_go
);
  localparam int SUM_W = ((POS_W > EST_W) ? POS_W : EST_W) + 1;

  logic [SUM_W-1:0] end_time;
  logic             fits;
  logic             valid_d;
  tok_stat_e        stat_d;
  logic             go_d;

  always_comb begin
    end_time = SUM_W'(pos) + SUM_W'(est);
    fits     = end_time <= SUM_W'(LIMIT);
    valid_d  = desc_valid;
    stat_d   = ST_NONE;
    go_d     = 1'b0;
    if (desc_valid) begin
      stat_d = fits ? ST_ISSUED : ST_TIMEOUT;
      go_d   = fits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat       <= ST_NONE;
      token_go   <= 1'b0;
    end else begin
      stat_valid <= valid_d;
      stat       <= stat_d;
      token_go   <= go_d;
    end
  end
endmodule

// File: rtl/frame_token_guard.sv
module frame_token_guard
  import ftg_pkg::*;
#(
  parameter int FRAME_TICKS    = 12000,
  parameter int GUARD_TICKS    = 42,
  parameter int OVERHEAD_TICKS = 50,
  parameter int LEN_W          = 11,
  parameter int POS_W          = $clog2(FRAME_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             tick,
  input  logic             desc_valid,
  input  logic [LEN_W-1:0] desc_len,
  output logic             stat_valid,
  output logic [1:0]       stat_code,
  output logic             token_go,
  output logic [POS_W-1:0] frame_pos
);
  localparam int EST_W = LEN_W + 6;
  localparam int LIMIT = FRAME_TICKS - GUARD_TICKS;

  logic [EST_W-1:0] est;
  tok_stat_e        stat;

  ftg_frame_pos #(.FRAME_TICKS(FRAME_TICKS), .POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .sof(sof), .tick(tick), .pos(frame_pos)
  );

  ftg_estimator #(.LEN_W(LEN_W), .OVERHEAD_TICKS(OVERHEAD_TICKS), .EST_W(EST_W)) u_est (
    .len(desc_len), .est(est)
  );

  ftg_decider #(.POS_W(POS_W), .EST_W(EST_W), .LIMIT(LIMIT)) u_dec (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .pos(frame_pos), .est(est),
    .stat_valid(stat_valid), .stat(stat), .token_go(token_go)
  );

  assign stat_code = stat;
endmodule

// File: rtl/frame_token_guard_chk.sv
module frame_token_guard_chk #(
  parameter int FRAME_TICKS = 12000,
  parameter int POS_W       = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sof,
  input logic             tick,
  input logic             desc_valid,
  input logic             stat_valid,
  input logic [1:0]       stat_code,
  input logic             token_go,
  input logic [POS_W-1:0] frame_pos
);
  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (frame_pos == '0)); // R2
  AST_POS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && !tick) |=> $stable(frame_pos)); // R2
  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pos <= POS_W'(FRAME_TICKS - 1)); // R3
  AST_TOKEN_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    token_go |-> (stat_valid && stat_code == 2'b01)); // R5
  AST_TIMEOUT_NO_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == 2'b10) |-> !token_go); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !desc_valid |=> (!stat_valid && stat_code == 2'b00 && !token_go)); // R7
  AST_VERDICT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |=> (stat_valid && stat_code != 2'b00)); // R8
endmodule

bind frame_token_guard frame_token_guard_chk #(
  .FRAME_TICKS(FRAME_TICKS), .POS_W(POS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .tick(tick), .desc_valid(desc_valid),
  .stat_valid(stat_valid), .stat_code(stat_code), .token_go(token_go),
  .frame_pos(frame_pos)
);

// File: tb/tb_frame_token_guard.sv
module tb_frame_token_guard;
  localparam int FRAME = 12000;
  localparam int GUARD = 42;
  localparam int OVH   = 50;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sof, tick, desc_valid;
  logic [10:0] desc_len;
  logic        stat_valid, token_go;
  logic [1:0]  stat_code;
  logic [13:0] frame_pos;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_pos = 0;
  int e_valid = 0, e_code = 0, e_go = 0;

  always #2 clk = ~clk;

  frame_token_guard dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .tick(tick), .desc_valid(desc_valid),
    .desc_len(desc_len), .stat_valid(stat_valid), .stat_code(stat_code),
    .token_go(token_go), .frame_pos(frame_pos)
  );

  function automatic int est_of(int len);
    return OVH + (len * 8 * 7 + 5) / 6;
  endfunction

  // behavioural reference, advanced on every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; e_valid = 0; e_code = 0; e_go = 0;
    end else begin
      if (desc_valid) begin
        e_valid = 1;
        if (m_pos + est_of(int'(desc_len)) <= FRAME - GUARD) begin e_code = 1; e_go = 1; end
        else begin e_code = 2; e_go = 0; end
      end else begin
        e_valid = 0; e_code = 0; e_go = 0;
      end
      if (sof) m_pos = 0;
      else if (tick && m_pos < FRAME - 1) m_pos = m_pos + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle compare against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk((e_code == 1) ? "R5 verdict" : (e_code == 2) ? "R6 verdict" : "R7 idle",
          int'(stat_valid), e_valid);
      chk((e_code == 1) ? "R5 code" : (e_code == 2) ? "R6 code" : "R7 code",
          int'(stat_code), e_code);
      chk((e_code == 1) ? "R5 token" : "R6_R7 token", int'(token_go), e_go);
      chk("R2_R3 frame_pos", int'(frame_pos), m_pos);
    end
  end

  task automatic go_to(int p);
    while (m_pos < p) begin tick = 1'b1; @(negedge clk); end
    tick = 1'b0;
  endtask

  task automatic present(int len, int exp_code, string req);
    desc_valid = 1'b1; desc_len = 11'(len);
    @(negedge clk);
    desc_valid = 1'b0;
    chk(req, int'(stat_code), exp_code);
    chk(req, int'(token_go), (exp_code == 1) ? 1 : 0);
  endtask

  task automatic frame_start();
    sof = 1'b1; @(negedge clk); sof = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sof = 1'b0; tick = 1'b0; desc_valid = 1'b0; desc_len = '0;
    repeat (3) @(negedge clk);
    chk("R1 stat_valid", int'(stat_valid), 0);
    chk("R1 stat_code", int'(stat_code), 0);
    chk("R1 token_go", int'(token_go), 0);
    chk("R1 frame_pos", int'(frame_pos), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(stat_valid), 0);

    frame_start();
    go_to(10);
    present(0, 1, "R5 empty packet early");
    present(1023, 1, "R5 max packet early");
    go_to(5000);
    present(1023, 2, "R6 max packet late");

    // R4 rounding: len=1 -> 50+10=60, last fitting pos 11898
    frame_start();
    go_to(11898);
    present(1, 1, "R4 len1 at limit");
    go_to(11899);
    present(1, 2, "R4 len1 one past");

    // R4 exact: len=3 -> 50+28=78, last fitting pos 11880
    frame_start();
    go_to(11880);
    present(3, 1, "R4 len3 at limit");
    go_to(11881);
    present(3, 2, "R4 len3 one past");
    go_to(11958);
    present(0, 2, "R6 inside guard band");

    // R3 saturation past nominal frame end
    tick = 1'b1;
    repeat (100) @(negedge clk);
    chk("R3 saturate", int'(frame_pos), FRAME - 1);
    tick = 1'b0;
    present(0, 2, "R6 saturated frame");

    // R2 sof wins over tick
    sof = 1'b1; tick = 1'b1; @(negedge clk);
    sof = 1'b0; tick = 1'b0;
    chk("R2 sof over tick", int'(frame_pos), 0);
    @(negedge clk);
    chk("R2 hold without tick", int'(frame_pos), 0);

    // R8 back-to-back descriptors with position moving: len=1 limit 11898
    go_to(11898);
    desc_valid = 1'b1; desc_len = 11'd1; tick = 1'b1;
    @(negedge clk);
    chk("R8 first back-to-back", int'(stat_code), 1);
    tick = 1'b0;
    @(negedge clk);
    desc_valid = 1'b0;
    chk("R8 second back-to-back", int'(stat_code), 2);
    @(negedge clk);
    chk("R7 idle after burst", int'(stat_valid), 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule